// File: doc/BRIEF.md
# Power Management Event Register Pair

This block holds two 16-bit registers that track platform power events and raise a level-sensitive system control interrupt (SCI). The pending register sits at the block base address. Hardware event inputs set its flags, and software acknowledges a flag by writing 1 to it. The mask register sits at base+2 and selects which pending flags may drive the interrupt. Only two of its bits can be written.

Software reaches both registers through one command channel that carries a valid/ready handshake. `cmd_ready` is held high in every cycle after reset, so the block never applies back-pressure. Each accepted command returns exactly one response on the following cycle. The response side has no ready signal, and the consumer must take `rsp_valid` in the cycle it appears. Event inputs are one-cycle-or-longer pulses sampled on the clock edge. The power-button input only takes effect while `pwrbtn_arm` is high. That input is driven from the interrupt-enable state held elsewhere.

Top module: `pm_evt_regs`

## Requirements
- R1: After reset both registers read 0x0000, `sci` is 0, `rsp_valid` is 0, and `cmd_ready` is 1 from the first cycle after reset.
- R2: A command is rejected when its size is not 2 bytes or its address is neither BASE_ADDR nor BASE_ADDR+2. A rejected command returns `rsp_err`=1 with `rsp_rdata`=0 and changes no register.
- R3: A read returns the register value from the cycle of acceptance, with `rsp_err`=0, one cycle after acceptance. A write response carries `rsp_rdata`=0.
- R4: Event inputs set pending bits, and those bits stay set until cleared: timer bit 0, bus master bit 4, global bit 5, sleep button bit 9, RTC bit 10, wake bit 15.
- R5: `ev_pwrbtn` sets pending bit 8 only while `pwrbtn_arm` is high. Otherwise it has no effect.
- R6: A write to the pending register clears each of bits 15, 10, 9, 8 and 4 that has a 1 in the write data. Bits 0 and 5 are never cleared by software, and written zeros change nothing.
- R7: A write to the mask register stores only bits 8 (power button) and 5 (global). All other mask bits read 0.
- R8: `sci` is high exactly while some bit among 0, 5, 8, 9 and 10 is set in both registers. It is updated in the cycle after any write or event. Bits 4 and 15 never drive it.
- R9: When an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R10: Every accepted command yields exactly one response, with `rsp_valid` high on the next cycle and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (high after reset) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_size | input | 3 | Access size in bytes |
| cmd_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_err | output | 1 | Command rejected |
| rsp_rdata | output | 16 | Read data |
| ev_tmr | input | 1 | Timer event |
| ev_bm | input | 1 | Bus master event |
| ev_gbl | input | 1 | Global event |
| ev_pwrbtn | input | 1 | Power-button event |
| ev_slpbtn | input | 1 | Sleep-button event |
| ev_rtc | input | 1 | RTC event |
| ev_wake | input | 1 | Wake event |
| pwrbtn_arm | input | 1 | Lets the power-button event through |
| sci | output | 1 | Level system control interrupt |

## Verification
The bench builds the block with ADDR_W=16 and BASE_ADDR=16'h0B00, not the default base. This shows that decode follows the parameter. It also puts the odd neighbour BASE_ADDR+1 and the out-of-range BASE_ADDR+4 within reach as rejected addresses. With these values the bench can drive every event source. It can then show the timer and global bits surviving an all-ones acknowledge, the set-wins collision on the power-button bit, and `sci` following the global and power-button mask pairs both up and down.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W = 16;

  localparam int B_TMR    = 0;
  localparam int B_BM     = 4;
  localparam int B_GBL    = 5;
  localparam int B_PWRBTN = 8;
  localparam int B_SLPBTN = 9;
  localparam int B_RTC    = 10;
  localparam int B_WAKE   = 15;

  // pending bits software may acknowledge by writing 1
  localparam logic [REG_W-1:0] ACK_MASK =
    (REG_W'(1) << B_WAKE) | (REG_W'(1) << B_RTC) | (REG_W'(1) << B_SLPBTN) |
    (REG_W'(1) << B_PWRBTN) | (REG_W'(1) << B_BM);

  // mask bits software may set
  localparam logic [REG_W-1:0] MASK_WR =
    (REG_W'(1) << B_PWRBTN) | (REG_W'(1) << B_GBL);

  // pairs taking part in the interrupt
  localparam logic [REG_W-1:0] IRQ_SRC =
    (REG_W'(1) << B_TMR) | (REG_W'(1) << B_GBL) | (REG_W'(1) << B_PWRBTN) |
    (REG_W'(1) << B_SLPBTN) | (REG_W'(1) << B_RTC);

  localparam logic [2:0] ACC_BYTES = 3'd2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pm_evt_decode.sv
module pm_evt_decode
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] MASK_ADDR = BASE_ADDR + ADDR_W'(2);

  always_comb begin
    sel = SEL_NONE;
    if (size == ACC_BYTES) begin
      if (addr == BASE_ADDR)      sel = SEL_PEND;
      else if (addr == MASK_ADDR) sel = SEL_MASK;
    end
  end
endmodule

// File: rtl/pm_evt_pending.sv
module pm_evt_pending
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_stb,
  input  logic [REG_W-1:0] ack_data,
  input  logic [REG_W-1:0] set_vec,
  output logic [REG_W-1:0] pend_q
);
  logic [REG_W-1:0] clr_vec;

  assign clr_vec = ack_stb ? (ack_data & ACK_MASK) : '0;

  // set is applied after clear so a colliding event survives
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/pm_evt_mask.sv
module pm_evt_mask
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      mask_q <= '0;
    else if (wr_stb) mask_q <= wr_data & MASK_WR;
  end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [2:0]        cmd_size,
  input  logic [15:0]       cmd_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [15:0]       rsp_rdata,
  input  logic              ev_tmr,
  input  logic              ev_bm,
  input  logic              ev_gbl,
  input  logic              ev_pwrbtn,
  input  logic              ev_slpbtn,
  input  logic              ev_rtc,
  input  logic              ev_wake,
  input  logic              pwrbtn_arm,
  output logic              sci
);
  reg_sel_e         sel;
  logic             accept;
  logic [REG_W-1:0] pend_q;
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] set_vec;
  logic             ready_q;

  pm_evt_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(cmd_addr), .size(cmd_size), .sel(sel)
  );

  assign accept = cmd_valid && ready_q;

  always_comb begin
    set_vec           = '0;
    set_vec[B_TMR]    = ev_tmr;
    set_vec[B_BM]     = ev_bm;
    set_vec[B_GBL]    = ev_gbl;
    set_vec[B_PWRBTN] = ev_pwrbtn && pwrbtn_arm;
    set_vec[B_SLPBTN] = ev_slpbtn;
    set_vec[B_RTC]    = ev_rtc;
    set_vec[B_WAKE]   = ev_wake;
  end

  pm_evt_pending u_pend (
    .clk(clk), .rst_n(rst_n),
    .ack_stb(accept && cmd_write && sel == SEL_PEND),
    .ack_data(cmd_wdata), .set_vec(set_vec), .pend_q(pend_q)
  );

  pm_evt_mask u_mask (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(accept && cmd_write && sel == SEL_MASK),
    .wr_data(cmd_wdata), .mask_q(mask_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      ready_q   <= 1'b1;
      rsp_valid <= accept;
      rsp_err   <= accept && (sel == SEL_NONE);
      rsp_rdata <= '0;
      if (accept && !cmd_write) begin
        if (sel == SEL_PEND)      rsp_rdata <= pend_q;
        else if (sel == SEL_MASK) rsp_rdata <= mask_q;
      end
    end
  end

  assign cmd_ready = ready_q;
  assign sci       = |(pend_q & mask_q & IRQ_SRC);
endmodule

// File: rtl/pm_evt_regs_chk.sv
module pm_evt_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [15:0] rsp_rdata,
  input logic [15:0] pend_q,
  input logic [15:0] mask_q,
  input logic        ev_any,
  input logic        pwrbtn_arm,
  input logic        sci
);
  a_r10_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cmd_ready);

  a_r10_one_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(cmd_valid && cmd_ready));

  a_r2_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 16'h0000));

  a_r5_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwrbtn_arm && !pend_q[8]) |=> !pend_q[8]);

  a_r6_tmr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[0] |=> pend_q[0]);

  a_r6_gbl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[5] |=> pend_q[5]);

  a_r7_mask_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(mask_q) |-> ((mask_q & 16'hFEDF) == 16'h0000));

  a_r8_sci_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sci) |-> $past(cmd_valid || ev_any));
endmodule

bind pm_evt_regs pm_evt_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .pend_q(pend_q), .mask_q(mask_q),
  .ev_any(ev_tmr | ev_bm | ev_gbl | ev_pwrbtn | ev_slpbtn | ev_rtc | ev_wake),
  .pwrbtn_arm(pwrbtn_arm), .sci(sci)
);

// File: tb/pm_evt_regs_test.sv
module pm_evt_regs_test;
  localparam logic [15:0] BASE = 16'h0B00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0, cmd_wdata = '0;
  logic [2:0]  cmd_size = '0;
  logic        cmd_ready, rsp_valid, rsp_err, sci;
  logic [15:0] rsp_rdata;
  logic        ev_tmr = 0, ev_bm = 0, ev_gbl = 0, ev_pwrbtn = 0;
  logic        ev_slpbtn = 0, ev_rtc = 0, ev_wake = 0, pwrbtn_arm = 0;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic        err;
    logic [15:0] data;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [15:0] m_pend = '0;
  logic [15:0] m_mask = '0;

  always #10 clk = ~clk;

  pm_evt_regs #(.ADDR_W(16), .BASE_ADDR(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .ev_tmr(ev_tmr), .ev_bm(ev_bm), .ev_gbl(ev_gbl),
    .ev_pwrbtn(ev_pwrbtn), .ev_slpbtn(ev_slpbtn), .ev_rtc(ev_rtc),
    .ev_wake(ev_wake), .pwrbtn_arm(pwrbtn_arm), .sci(sci)
  );

  function automatic logic exp_sci();
    return |(m_pend & m_mask & 16'h0721);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one command; expectation is computed from the bench model
  task automatic cmd(input bit wr, input logic [15:0] a, input logic [2:0] sz,
                     input logic [15:0] d, input logic [15:0] evset, input string tag);
    exp_t e;
    bit ok;
    ok = (sz == 3'd2) && (a == BASE || a == BASE + 16'd2);
    e.err = !ok; e.data = 16'h0; e.tag = tag;
    if (ok && !wr) e.data = (a == BASE) ? m_pend : m_mask;
    if (ok && wr) begin
      if (a == BASE) m_pend = m_pend & ~(d & 16'h8710);
      else           m_mask = d & 16'h0120;
    end
    m_pend = m_pend | evset;
    sb.push_back(e);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_size = sz; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0;
    ev_pwrbtn = 0;
  endtask

  task automatic events(input logic [15:0] v, input bit arm);
    pwrbtn_arm = arm;
    {ev_wake, ev_rtc, ev_slpbtn, ev_pwrbtn, ev_gbl, ev_bm, ev_tmr} =
      {v[15], v[10], v[9], v[8], v[5], v[4], v[0]};
    m_pend = m_pend | (v & (arm ? 16'h8731 : 16'h8631));
    @(negedge clk);
    {ev_wake, ev_rtc, ev_slpbtn, ev_pwrbtn, ev_gbl, ev_bm, ev_tmr} = '0;
  endtask

  task automatic chk_sci(input string tag);
    check(sci === exp_sci(), tag, {15'h0, sci}, {15'h0, exp_sci()});
  endtask

  // monitor: compare every response against the queue head
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid === 1'b1) begin
        if (sb.size() == 0) begin
          check(0, "R10 unexpected response", rsp_rdata, 16'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_err === e.err, {e.tag, " err"}, {15'h0, rsp_err}, {15'h0, e.err});
          check(rsp_rdata === e.data, {e.tag, " data"}, rsp_rdata, e.data);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sci === 1'b0 && rsp_valid === 1'b0, "R1 outputs in reset",
          {14'h0, sci, rsp_valid}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    check(cmd_ready === 1'b1, "R1 ready after reset", {15'h0, cmd_ready}, 16'h1);
    cmd(0, BASE, 3'd2, 0, 0, "R1 pending reset value");
    cmd(0, BASE + 16'd2, 3'd2, 0, 0, "R1 mask reset value");

    // R2 rejected sizes and addresses
    cmd(0, BASE, 3'd1, 0, 0, "R2 byte read");
    cmd(1, BASE + 16'd2, 3'd4, 16'hFFFF, 0, "R2 dword write");
    cmd(1, BASE + 16'd1, 3'd2, 16'hFFFF, 0, "R2 odd address");
    cmd(0, BASE + 16'd4, 3'd2, 0, 0, "R2 address past block");
    cmd(0, BASE + 16'd2, 3'd2, 0, 0, "R2 mask unchanged by rejects");

    // R7 writable mask bits, R3 write response data
    cmd(1, BASE + 16'd2, 3'd2, 16'hFFFF, 0, "R3 write response");
    cmd(0, BASE + 16'd2, 3'd2, 0, 0, "R7 mask keeps bits 8 and 5");
    chk_sci("R8 idle sci low");

    // R5 power button arm gating
    events(16'h0100, 0);
    cmd(0, BASE, 3'd2, 0, 0, "R5 disarmed button ignored");
    chk_sci("R5 sci stays low");
    events(16'h0100, 1);
    chk_sci("R8 sci from power button");
    cmd(0, BASE, 3'd2, 0, 0, "R5 armed button sets bit 8");
    cmd(1, BASE, 3'd2, 16'h0100, 0, "R6 ack power button");
    chk_sci("R8 sci drops after ack");
    cmd(0, BASE, 3'd2, 0, 0, "R6 bit 8 cleared");

    // R4 every source, R6 ack all
    events(16'h8731, 1);
    cmd(0, BASE, 3'd2, 0, 0, "R4 all sources set");
    cmd(1, BASE, 3'd2, 16'h0000, 0, "R6 zero write");
    cmd(0, BASE, 3'd2, 0, 0, "R6 zero write changes nothing");
    cmd(1, BASE, 3'd2, 16'hFFFF, 0, "R6 ack all ones");
    cmd(0, BASE, 3'd2, 0, 0, "R6 timer and global remain");
    chk_sci("R8 sci from global pair");
    cmd(1, BASE + 16'd2, 3'd2, 16'h0100, 0, "R7 mask power only");
    chk_sci("R8 sci low, timer/global not masked in");

    // R8 bus master and wake never drive sci
    events(16'h8010, 1);
    cmd(1, BASE + 16'd2, 3'd2, 16'hFFFF, 0, "R8 mask all");
    chk_sci("R8 sci from global with bm/wake pending");
    cmd(1, BASE + 16'd2, 3'd2, 16'h0000, 0, "R8 mask none");
    chk_sci("R8 bm/wake alone keep sci low");

    // R9 set wins over same-cycle ack
    pwrbtn_arm = 1; ev_pwrbtn = 1;
    cmd(1, BASE, 3'd2, 16'h0100, 16'h0100, "R9 collide write");
    cmd(0, BASE, 3'd2, 0, 0, "R9 bit 8 survives collision");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R10 all responses returned", 16'(sb.size()), 16'h0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule